// File: doc/BRIEF.md
# Supply Supervisor Reset Release Timer

This block sequences the reset line of a supply supervisor. It takes two comparator results from analog circuitry outside the block. `sup_low_i` is high while the supply sits under the trip level. `sup_ok_i` is high while the supply sits over the trip level plus hysteresis. From these the block drives an active-low reset, `rst_out_n`. A drop under the trip level pulls the reset low at once. The reset is let go only after the supply has climbed past the upper level and a chosen wait has run out.

Two static strap inputs, `dsel_a_i` and `dsel_b_i`, choose the wait. The choices are zero (a short bypass of about 100 µs), 50 ms, 100 ms and 200 ms. The block converts each wait into clock ticks using the parameter `CLK_HZ`. All four inputs are asynchronous, and each passes through two flops before the block uses it. There is no data stream, so every pin is a plain level.

Top module: `supply_reset_sequencer`

## Requirements
- R1: During and right after the synchronous reset `rst`, `rst_out_n` is 0 and the wait counter is clear.
- R2: When `sup_low_i` rises, `rst_out_n` is 0 at the third rising clock edge after the change. Two edges are spent in synchronization and one in the output register.
- R3: While `sup_ok_i` stays 0, `rst_out_n` stays 0, even when `sup_low_i` is 0.
- R4: When `sup_ok_i` rises with `sup_low_i` at 0, `rst_out_n` rises at exactly edge 3+T after the change, where T is the tick count of the selected wait.
- R5: The strap code {dsel_a_i, dsel_b_i} selects T as follows. 2'b11 gives max(1, CLK_HZ/10000) ticks (the 100 µs bypass). 2'b10 gives CLK_HZ*50/1000. 2'b01 gives CLK_HZ*100/1000. 2'b00 gives CLK_HZ*200/1000.
- R6: If `sup_low_i` rises while a wait is running, the counter clears and `rst_out_n` stays 0. After `sup_ok_i` is next seen high, a fresh full wait of T ticks is timed from that point.
- R7: The strap code is captured when the wait begins. A change of code during the wait neither shortens nor stretches it.
- R8: Once released, `rst_out_n` stays 1 while `sup_low_i` is 0, even if `sup_ok_i` falls, because the supply is then inside the hysteresis band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; its frequency is the `CLK_HZ` parameter |
| rst | input | 1 | Synchronous reset, active high |
| sup_low_i | input | 1 | Asynchronous: supply is under the trip level |
| sup_ok_i | input | 1 | Asynchronous: supply is over the trip level plus hysteresis |
| dsel_a_i | input | 1 | Asynchronous wait-select strap, upper code bit |
| dsel_b_i | input | 1 | Asynchronous wait-select strap, lower code bit |
| rst_out_n | output | 1 | Reset to downstream logic, active low |

## Verification
The bench changes each input half a cycle away from a rising edge. It then counts rising edges until the output responds. A fall of the output is due on the third edge. A release is due on edge 3+T, where T is worked out by a bench function from the strap code and `CLK_HZ`. The bench samples on falling edges, so the edge count it records can be compared exactly with these figures. For the abort and strap-change cases, the count starts again at the input change that begins the valid wait, and the same 3+T figure applies.

// File: rtl/supsv_pkg.sv
package supsv_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_COUNT = 2'd1,
    ST_RUN   = 2'd2
  } rel_state_e;

  // Ticks of a clock at clk_hz spanning us microseconds, never below one.
  function automatic longint ticks_for(input longint clk_hz, input longint us);
    longint t;
    t = (clk_hz * us) / 64'd1000000;
    if (t < 64'd1) t = 64'd1;
    return t;
  endfunction

endpackage

// File: rtl/supsv_sync2.sv
module supsv_sync2 #(
  parameter int              W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= RST_VAL[i];
        stab_q <= RST_VAL[i];
      end else begin
        meta_q <= d[i];
        stab_q <= meta_q;
      end
    end
    assign q[i] = stab_q;
  end

endmodule

// File: rtl/supsv_delay_lut.sv
module supsv_delay_lut #(
  parameter longint CLK_HZ = 1000000,
  parameter int     CW     = 18
) (
  input  logic [1:0]    code,
  output logic [CW-1:0] term
);

  localparam longint T_BYP = supsv_pkg::ticks_for(CLK_HZ, 100);
  localparam longint T_50  = supsv_pkg::ticks_for(CLK_HZ, 50000);
  localparam longint T_100 = supsv_pkg::ticks_for(CLK_HZ, 100000);
  localparam longint T_200 = supsv_pkg::ticks_for(CLK_HZ, 200000);

  always_comb begin
    unique case (code)
      2'b11:   term = CW'(T_BYP);
      2'b10:   term = CW'(T_50);
      2'b01:   term = CW'(T_100);
      default: term = CW'(T_200);
    endcase
  end

endmodule

// File: rtl/supsv_release_timer.sv
module supsv_release_timer #(
  parameter int CW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          low_s,
  input  logic          ok_s,
  input  logic [CW-1:0] term_in,
  output logic          rst_n_o
);
  import supsv_pkg::*;

  rel_state_e    state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] target;
  logic          rst_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HOLD;
      cnt     <= '0;
      target  <= '0;
      rst_n_q <= 1'b0;
    end else if (low_s) begin
      state   <= ST_HOLD;
      cnt     <= '0;
      rst_n_q <= 1'b0;
    end else begin
      unique case (state)
        ST_HOLD: begin
          if (ok_s) begin
            state  <= ST_COUNT;
            cnt    <= '0;
            target <= term_in;
          end
        end
        ST_COUNT: begin
          if (cnt == target - CW'(1)) begin
            state   <= ST_RUN;
            cnt     <= '0;
            rst_n_q <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_RUN: begin
          rst_n_q <= 1'b1;
        end
        default: begin
          state   <= ST_HOLD;
          rst_n_q <= 1'b0;
        end
      endcase
    end
  end

  assign rst_n_o = rst_n_q;

  assert_drop_asserts_R2: assert property (@(posedge clk) disable iff (rst)
    low_s |=> (!rst_n_q && cnt == '0));

  assert_hold_without_ok_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && !ok_s) |=> !rst_n_q);

  assert_rise_after_full_wait_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_q) |-> ($past(state) == ST_COUNT && $past(cnt) == $past(target) - CW'(1)));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COUNT) |-> (cnt < target));

  assert_target_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COUNT && $past(state) == ST_COUNT) |-> $stable(target));

  assert_stay_released_R8: assert property (@(posedge clk) disable iff (rst)
    (rst_n_q && !low_s) |=> rst_n_q);

endmodule

// File: rtl/supply_reset_sequencer.sv
module supply_reset_sequencer #(
  parameter longint CLK_HZ = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic sup_low_i,
  input  logic sup_ok_i,
  input  logic dsel_a_i,
  input  logic dsel_b_i,
  output logic rst_out_n
);

  localparam longint T_MAX = supsv_pkg::ticks_for(CLK_HZ, 200000);
  localparam int     CW    = $clog2(T_MAX + 1);

  logic [3:0]    raw_in;
  logic [3:0]    syn_in;
  logic [CW-1:0] term;

  assign raw_in = {dsel_a_i, dsel_b_i, sup_ok_i, sup_low_i};

  supsv_sync2 #(
    .W       (4),
    .RST_VAL (4'b0001)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_in)
  );

  supsv_delay_lut #(
    .CLK_HZ (CLK_HZ),
    .CW     (CW)
  ) u_lut (
    .code (syn_in[3:2]),
    .term (term)
  );

  supsv_release_timer #(
    .CW (CW)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .low_s   (syn_in[0]),
    .ok_s    (syn_in[1]),
    .term_in (term),
    .rst_n_o (rst_out_n)
  );

  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> !rst_out_n);

endmodule

// File: tb/supply_reset_sequencer_test.sv
module supply_reset_sequencer_test;

  localparam int     CLK_PERIOD = 10;
  localparam longint TB_HZ      = 10000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sup_low = 1'b1;
  logic sup_ok = 1'b0;
  logic sel_a = 1'b0;
  logic sel_b = 1'b0;
  logic rst_out_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  supply_reset_sequencer #(.CLK_HZ(TB_HZ)) uut (
    .clk       (clk),
    .rst       (rst),
    .sup_low_i (sup_low),
    .sup_ok_i  (sup_ok),
    .dsel_a_i  (sel_a),
    .dsel_b_i  (sel_b),
    .rst_out_n (rst_out_n)
  );

  function automatic int exp_ticks(input logic a, input logic b);
    longint t;
    case ({a, b})
      2'b11:   t = TB_HZ / 10000;
      2'b10:   t = TB_HZ * 50 / 1000;
      2'b01:   t = TB_HZ * 100 / 1000;
      default: t = TB_HZ * 200 / 1000;
    endcase
    if (t < 1) t = 1;
    return int'(t);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count edges from now until rst_out_n is 1 (bounded).
  task automatic edges_to_release(output int k);
    k = 0;
    while (rst_out_n == 1'b0 && k < 5000) begin
      step();
      k++;
    end
  endtask

  task automatic drop_supply();
    sup_low = 1'b1;
    sup_ok  = 1'b0;
    repeat (4) step();
  endtask

  task automatic raise_and_measure(input logic a, input logic b, input string req);
    int k;
    int e;
    sel_a = a;
    sel_b = b;
    repeat (3) step();
    sup_low = 1'b0;
    sup_ok  = 1'b1;
    edges_to_release(k);
    e = 3 + exp_ticks(a, b);
    check(k == e, req, k, e);
  endtask

  initial begin
    int k;
    int e;
    int lo;
    void'($urandom(32'd4177));
    @(negedge clk);
    repeat (3) step();
    // R1: held in reset
    check(rst_out_n == 1'b0, "R1 during reset", int'(rst_out_n), 0);
    rst = 1'b0;
    repeat (5) step();
    check(rst_out_n == 1'b0, "R1 after reset", int'(rst_out_n), 0);

    // R4/R5: each code
    raise_and_measure(1'b1, 1'b1, "R5 code 11 bypass");
    drop_supply();
    raise_and_measure(1'b1, 1'b0, "R5 code 10");
    // R2: fall latency
    sup_low = 1'b1;
    sup_ok  = 1'b0;
    step();
    step();
    check(rst_out_n == 1'b1, "R2 not before edge 3", int'(rst_out_n), 1);
    step();
    check(rst_out_n == 1'b0, "R2 low at edge 3", int'(rst_out_n), 0);
    raise_and_measure(1'b0, 1'b1, "R4 code 01");
    drop_supply();
    raise_and_measure(1'b0, 1'b0, "R4 code 00");

    // R8: hysteresis band keeps output released
    sup_ok = 1'b0;
    repeat (60) step();
    check(rst_out_n == 1'b1, "R8 band after release", int'(rst_out_n), 1);

    // R3: low flag cleared but ok flag absent
    drop_supply();
    sup_low = 1'b0;
    repeat (80) step();
    check(rst_out_n == 1'b0, "R3 held without ok", int'(rst_out_n), 0);

    // R6: abort mid-wait, then fresh full wait
    sel_a = 1'b1; sel_b = 1'b0;
    repeat (3) step();
    sup_ok = 1'b1;
    repeat (250) step();
    sup_low = 1'b1; sup_ok = 1'b0;
    repeat (20) step();
    check(rst_out_n == 1'b0, "R6 low after abort", int'(rst_out_n), 0);
    sup_low = 1'b0; sup_ok = 1'b1;
    edges_to_release(k);
    e = 3 + exp_ticks(1'b1, 1'b0);
    check(k == e, "R6 fresh full wait", k, e);

    // R7: code change during wait has no effect
    drop_supply();
    sel_a = 1'b0; sel_b = 1'b0;
    repeat (3) step();
    sup_low = 1'b0; sup_ok = 1'b1;
    repeat (100) step();
    sel_a = 1'b1; sel_b = 1'b1;
    edges_to_release(k);
    k = k + 100;
    e = 3 + exp_ticks(1'b0, 1'b0);
    check(k == e, "R7 code captured at start", k, e);

    // Random trials, some with an abort
    for (int t = 0; t < 10; t++) begin
      logic ra;
      logic rb;
      bit   ab;
      drop_supply();
      ra = 1'($urandom());
      rb = 1'($urandom());
      ab = 1'($urandom());
      sel_a = ra; sel_b = rb;
      repeat (3) step();
      sup_low = 1'b0; sup_ok = 1'b1;
      if (ab && exp_ticks(ra, rb) > 10) begin
        lo = 4 + int'($urandom_range(0, 300));
        if (lo > exp_ticks(ra, rb)) lo = exp_ticks(ra, rb);
        repeat (lo) step();
        sup_low = 1'b1; sup_ok = 1'b0;
        repeat (5) step();
        check(rst_out_n == 1'b0, "R6 random abort", int'(rst_out_n), 0);
        sup_low = 1'b0; sup_ok = 1'b1;
      end
      edges_to_release(k);
      e = 3 + exp_ticks(ra, rb);
      check(k == e, "R4 random release", k, e);
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule